// File: doc/BRIEF.md
# PWM Generator with Deferred Update

This block produces one pulse-width-modulated output from a single 32-bit control word. The output rate comes from a fractional increment, the base unit, that is added every clock to a phase accumulator as wide as that increment. Each wrap of the accumulator starts a new output cycle. The duty cycle is set by an 8-bit on-time divisor: the output is high while the top eight accumulator bits are below 255 minus the divisor.

Software writes the whole control word at once. A written base unit and divisor are staged first, and become active only when software also sets the update-request bit. The request is honoured at the next output-cycle start, and the bit then clears itself. While a request is pending the control word is locked, so software polls the readback until the bit drops. A small state machine tracks whether the generator is off (`ST_OFF`), enabled with a zero rate (`ST_STALL`) or counting (`ST_RUN`). Its transitions are: start (OFF to RUN, or OFF to STALL when the active rate is zero), rate-zeroed (RUN to STALL), rate-set (STALL to RUN) and shutdown (any state to OFF when enable drops). When the generator is not counting there is no cycle in progress, so a pending request is applied on the very next clock.

Top module: `pwm_deferred_gen`

## Requirements
- R1: After reset the readback is all zeros and the output is low.
- R2: A write accepted with no update pending stores bit 31 as enable, bit 30 as update request, bits 8 and up (BU_W bits) as base unit and bits 7:0 as divisor; the readback returns exactly these fields with every other bit zero.
- R3: With active base unit B and enable set, the accumulator advances by B each clock, giving one rising output edge every 2^BU_W / B clocks.
- R4: While counting, the output is high exactly when the top 8 accumulator bits are below 255 minus the active divisor; a divisor of 255 keeps it low and a divisor of 0 keeps it high for rates whose top byte never reaches 255.
- R5: A set update request copies the staged base unit and divisor into the active pair at the next accumulator wrap; until then the readback shows bit 30 set, afterwards clear.
- R6: A write that arrives while bit 30 reads set changes neither the enable, the staged fields nor the active fields.
- R7: With enable clear the accumulator is held at zero and the output is low; a pending update request is applied on the next clock.
- R8: With an active base unit of 0 the accumulator does not advance and the output stays low; a later update to a non-zero rate restarts counting.
- R9: A write landing in the same cycle that a pending update completes is dropped, because the request bit is still set when it arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Readback of the control word, including the live update-request bit |
| pwm_out | output | 1 | PWM output |

## Verification
The collision of interest is a software write arriving in the very cycle that a pending update completes and the request bit clears. It is provoked deterministically while the generator is disabled: a write carrying an update request is followed immediately by a second write, so the request is applied at the edge where the second write lands. The readback must then show the first word with the request bit cleared, and a later enabled run must show the first word's rate and duty, proving the second word was dropped at the boundary rather than slipping in as the lock released.

// File: rtl/pwmdu_pkg.sv
package pwmdu_pkg;
    localparam int CTL_W   = 32;
    localparam int EN_BIT  = 31;
    localparam int UPD_BIT = 30;
    localparam int BU_LSB  = 8;
    localparam int DIV_W   = 8;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_STALL = 2'd1,
        ST_RUN   = 2'd2
    } run_state_e;
endpackage

// File: rtl/pwmdu_ctrl_reg.sv
module pwmdu_ctrl_reg
    import pwmdu_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             apply,
    output logic             en,
    output logic             upd,
    output logic [BU_W-1:0]  bu_stage,
    output logic [DIV_W-1:0] div_stage,
    output logic [CTL_W-1:0] rd_data
);
    localparam int PAD_LSB = BU_LSB + BU_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= 1'b0;
            upd       <= 1'b0;
            bu_stage  <= '0;
            div_stage <= '0;
        end else if (wr_en && !upd) begin
            en        <= wr_data[EN_BIT];
            upd       <= wr_data[UPD_BIT];
            bu_stage  <= wr_data[BU_LSB +: BU_W];
            div_stage <= wr_data[DIV_W-1:0];
        end else if (apply) begin
            upd <= 1'b0;
        end
    end

    always_comb begin
        rd_data                   = '0;
        rd_data[EN_BIT]           = en;
        rd_data[UPD_BIT]          = upd;
        rd_data[BU_LSB +: BU_W]   = bu_stage;
        rd_data[DIV_W-1:0]        = div_stage;
    end

    generate
        if (PAD_LSB < UPD_BIT) begin : g_pad
            logic unused_pad;
            assign unused_pad = ^wr_data[UPD_BIT-1:PAD_LSB];
        end
    endgenerate
endmodule

// File: rtl/pwmdu_shadow.sv
module pwmdu_shadow
    import pwmdu_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  logic [BU_W-1:0]  bu_stage,
    input  logic [DIV_W-1:0] div_stage,
    output logic [BU_W-1:0]  bu_act,
    output logic [DIV_W-1:0] div_act
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bu_act  <= '0;
            div_act <= '0;
        end else if (apply) begin
            bu_act  <= bu_stage;
            div_act <= div_stage;
        end
    end
endmodule

// File: rtl/pwmdu_phase.sv
module pwmdu_phase
    import pwmdu_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [BU_W-1:0]  bu_act,
    input  logic [DIV_W-1:0] div_act,
    output logic             wrap,
    output logic             pwm_raw
);
    localparam int TOP_LSB = BU_W - DIV_W;
    localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};

    logic [BU_W-1:0] acc_q;
    logic [BU_W:0]   sum;
    logic [DIV_W-1:0] thresh;

    assign sum    = {1'b0, acc_q} + {1'b0, bu_act};
    assign wrap   = run && sum[BU_W];
    assign thresh = DIV_MAX - div_act;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum[BU_W-1:0];
        end
    end

    assign pwm_raw = acc_q[BU_W-1:TOP_LSB] < thresh;
endmodule

// File: rtl/pwm_deferred_gen.sv
module pwm_deferred_gen
    import pwmdu_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    run_state_e       state_q, state_d;
    logic             en, upd, apply, cycle_start, wrap, pwm_raw, run;
    logic [BU_W-1:0]  bu_stage, bu_act, bu_next;
    logic [DIV_W-1:0] div_stage, div_act;

    pwmdu_ctrl_reg #(.BU_W(BU_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .apply     (apply),
        .en        (en),
        .upd       (upd),
        .bu_stage  (bu_stage),
        .div_stage (div_stage),
        .rd_data   (rd_data)
    );

    pwmdu_shadow #(.BU_W(BU_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply     (apply),
        .bu_stage  (bu_stage),
        .div_stage (div_stage),
        .bu_act    (bu_act),
        .div_act   (div_act)
    );

    pwmdu_phase #(.BU_W(BU_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .bu_act  (bu_act),
        .div_act (div_act),
        .wrap    (wrap),
        .pwm_raw (pwm_raw)
    );

    // A cycle boundary is a wrap, or any clock while no cycle is in progress.
    assign run         = (state_q == ST_RUN);
    assign cycle_start = !run || wrap;
    assign apply       = upd && cycle_start;
    assign bu_next     = apply ? bu_stage : bu_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en) begin
                    state_d = (bu_next == '0) ? ST_STALL : ST_RUN;
                end
            end
            ST_STALL: begin
                if (!en) begin
                    state_d = ST_OFF;
                end else if (bu_next != '0) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_OFF;
                end else if (bu_next == '0) begin
                    state_d = ST_STALL;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:   pwm_out = pwm_raw;
            ST_OFF,
            ST_STALL: pwm_out = 1'b0;
            default:  pwm_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwmdu_checker.sv
module pwmdu_checker
    import pwmdu_pkg::*;
#(
    parameter int BU_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_upd,
    input logic [31:0]      rd_data,
    input logic             pwm_out,
    input logic [BU_W-1:0]  bu_act,
    input logic [DIV_W-1:0] div_act
);
    assert_locked_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[UPD_BIT] && wr_en) |=>
            (rd_data[EN_BIT] == $past(rd_data[EN_BIT])) &&
            (rd_data[UPD_BIT-1:0] == $past(rd_data[UPD_BIT-1:0])));

    assert_req_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[UPD_BIT]) |-> $past(wr_en && wr_upd));

    assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[EN_BIT] |=> !pwm_out);

    assert_div_max_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_act == {DIV_W{1'b1}}) |-> !pwm_out);

    assert_zero_rate_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bu_act == '0) |-> !pwm_out);

    assert_active_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bu_act) |-> $fell(rd_data[UPD_BIT]));
endmodule

bind pwm_deferred_gen pwmdu_checker #(.BU_W(BU_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_upd  (wr_data[30]),
    .rd_data (rd_data),
    .pwm_out (pwm_out),
    .bu_act  (bu_act),
    .div_act (div_act)
);

// File: tb/pwm_deferred_gen_tb.sv
module pwm_deferred_gen_tb;
    localparam int BU_W = 16;
    localparam int NV   = 6;
    localparam int WIN  = 1024;
    // fields: base unit [55:40], divisor [39:32], high count [31:16], rising edges [15:0]
    localparam logic [55:0] VEC [NV] = '{
        {16'h4000, 8'd127, 16'd512,  16'd256},
        {16'h4000, 8'd0,   16'd1024, 16'd0},
        {16'h4000, 8'd255, 16'd0,    16'd0},
        {16'h1000, 8'd191, 16'd256,  16'd64},
        {16'h0100, 8'd55,  16'd800,  16'd4},
        {16'h8000, 8'd200, 16'd512,  16'd512}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pwm_deferred_gen #(.BU_W(BU_W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    function automatic logic [31:0] word(bit e, bit u, logic [15:0] bu, logic [7:0] dv);
        logic [31:0] w = '0;
        w[31] = e;
        w[30] = u;
        w[8 +: BU_W] = bu;
        w[7:0] = dv;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_clear(input string req);
        int n = 0;
        while (rd_data[30] && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(!rd_data[30], req, rd_data[30], 0);
    endtask

    task automatic measure(output int hi, output int rs);
        logic prev;
        hi = 0;
        rs = 0;
        prev = pwm_out;
        repeat (WIN) begin
            @(negedge clk);
            if (pwm_out) hi++;
            if (pwm_out && !prev) rs++;
            prev = pwm_out;
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int hi, rs;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == 32'h0, "R1 readback", rd_data, 0);
        chk(pwm_out == 1'b0, "R1 output", pwm_out, 0);

        // Table walk: R2 fields, R3 rate, R4 duty, R5 deferred apply
        for (int i = 0; i < NV; i++) begin
            logic [55:0] v = VEC[i];
            wr(word(1'b1, 1'b1, v[55:40], v[39:32]));
            wait_clear("R5 request clears");
            chk(rd_data == word(1'b1, 1'b0, v[55:40], v[39:32]), "R2 readback",
                rd_data, word(1'b1, 1'b0, v[55:40], v[39:32]));
            measure(hi, rs);
            chk(hi == int'(v[31:16]), "R4 high count", hi, v[31:16]);
            chk(rs == int'(v[15:0]), "R3 rising edges", rs, v[15:0]);
        end

        // R6 lockout while pending, R5 applied at next wrap
        wr(word(1'b1, 1'b1, 16'h0100, 8'd55));
        wait_clear("R5 request clears");
        wr(word(1'b1, 1'b1, 16'h0200, 8'd100));
        wr(word(1'b1, 1'b1, 16'h0300, 8'd10));
        chk(rd_data == word(1'b1, 1'b1, 16'h0200, 8'd100), "R6 locked write",
            rd_data, word(1'b1, 1'b1, 16'h0200, 8'd100));
        wait_clear("R5 request clears");
        chk(rd_data == word(1'b1, 1'b0, 16'h0200, 8'd100), "R5 readback after apply",
            rd_data, word(1'b1, 1'b0, 16'h0200, 8'd100));
        measure(hi, rs);
        chk(hi == 624, "R5 new duty active", hi, 624);
        chk(rs == 8, "R5 new rate active", rs, 8);

        // R7 disabled output low
        wr(word(1'b0, 1'b0, 16'h0200, 8'd100));
        @(negedge clk);
        measure(hi, rs);
        chk(hi == 0, "R7 disabled output", hi, 0);

        // R9 write in the cycle the pending update completes (disabled, so next clock)
        wr(word(1'b0, 1'b1, 16'h4000, 8'd127));
        wr(word(1'b1, 1'b1, 16'h1000, 8'd0));
        chk(rd_data == word(1'b0, 1'b0, 16'h4000, 8'd127), "R9 colliding write dropped",
            rd_data, word(1'b0, 1'b0, 16'h4000, 8'd127));
        wr(word(1'b1, 1'b0, 16'h4000, 8'd127));
        @(negedge clk);
        measure(hi, rs);
        chk(hi == 512, "R7 applied while off duty", hi, 512);
        chk(rs == 256, "R9 active rate from first word", rs, 256);

        // R8 zero base unit: no cycles, output low; then restart
        wr(word(1'b1, 1'b1, 16'h0000, 8'd0));
        wait_clear("R8 request clears");
        measure(hi, rs);
        chk(hi == 0, "R8 zero rate output", hi, 0);
        chk(rs == 0, "R8 zero rate edges", rs, 0);
        wr(word(1'b1, 1'b1, 16'h4000, 8'd127));
        wait_clear("R8 request clears from stall");
        measure(hi, rs);
        chk(hi == 512, "R8 restart duty", hi, 512);
        chk(rs == 256, "R8 restart rate", rs, 256);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule